// File: doc/BRIEF.md
# Sleep Entry and Wake Guard Controller

This block sequences a synchronous memory into and out of a low-power sleep state. A sleep request arrives asynchronously and active high. It is synchronized, then starts an entry window. During that window the memory is forced deselected and its output drivers are turned off while the internal clock keeps running. When the window ends, the internal clock enable drops and the memory sleeps. Stored contents are never touched by this sequencing.

Dropping the request does not wake the memory. A recovery window follows first, with the clock running but the memory still deselected. After that the block holds a low-power idle state. It stays there until the decoded "new read or write command" input fires, and only then does it return to normal operation with outputs enabled. The entry and recovery windows are fixed times that the block converts to clock cycles from its period parameter, rounding up.

A command strobe or a write assertion that lands inside the entry or recovery window breaks the protocol. Such an event sets a sticky violation flag, and the array write gate stays closed outside the awake and idle states.

Top module: `sleep_guard_ctrl`

## Requirements
- R1: After reset the block is awake: `icg_en_o`=1, `desel_o`=0, `drv_off_o`=0, `proto_err_o`=0.
- R2: A rise of `sleep_req_i` is passed through SYNC_STAGES flops. The entry window begins on the clock edge SYNC_STAGES+1 after the request is first sampled (edge 3 by default). Until then the outputs stay in the awake pattern.
- R3: The entry window lasts ENTRY_CYC = ceil(ENTRY_TIME_PS / CLK_PERIOD_PS) cycles with `icg_en_o`=1, `desel_o`=1, `drv_off_o`=1. It then always enters sleep, even if the request has already been removed.
- R4: In sleep, `icg_en_o`=0, `desel_o`=1, `drv_off_o`=1. Commands and writes there neither set the error flag nor open `wr_ok_o`.
- R5: The recovery window starts SYNC_STAGES+1 edges after the request falls while asleep. It lasts RECOV_CYC = ceil(RECOVER_TIME_PS / CLK_PERIOD_PS) cycles with `icg_en_o`=1, `desel_o`=1, `drv_off_o`=1.
- R6: After recovery the block idles with `icg_en_o`=1, `desel_o`=0, `drv_off_o`=1 until `cmd_start_i` is seen. From the next cycle it is awake (`drv_off_o`=0).
- R7: `cmd_start_i` or `wr_req_i` high during an entry or recovery window sets `proto_err_o` from the next cycle. The flag stays set until reset.
- R8: `wr_ok_o` equals `wr_req_i` while awake or idle after recovery, and is 0 in every other state.
- R9: A request that reappears during the idle state (or during recovery) starts a new entry window SYNC_STAGES+1 edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req_i | input | 1 | Asynchronous active-high sleep request |
| cmd_start_i | input | 1 | Decoded new read/write command this cycle |
| wr_req_i | input | 1 | Write assertion this cycle |
| icg_en_o | output | 1 | Internal clock enable |
| desel_o | output | 1 | Forced deselect of the memory |
| drv_off_o | output | 1 | Output driver disable |
| wr_ok_o | output | 1 | Gated array write enable |
| proto_err_o | output | 1 | Sticky protocol violation flag |

## Verification
A wrong state in this block shows at once as a wrong triple of clock enable, deselect and driver disable, because each state has a distinct pattern. A bad window counter shows as that pattern changing one or more cycles early or late after a request edge. The bench sweeps the cycle of a command pulse across every slot around entry and around recovery. A window boundary that is off by one therefore shows either as an error flag in the wrong slot, on the very next cycle, or as a write gate that opens when it should stay shut.

// File: rtl/sleep_guard_pkg.sv
package sleep_guard_pkg;

   typedef enum logic [2:0] {
      PS_AWAKE   = 3'd0,
      PS_ENTRY   = 3'd1,
      PS_ASLEEP  = 3'd2,
      PS_RECOVER = 3'd3,
      PS_IDLE    = 3'd4
   } pwr_state_t;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int cnt_width(input int max_val);
      int w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction

endpackage

// File: rtl/sleep_guard_sync.sv
module sleep_guard_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sleep_guard_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic stage_q;
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= g_stage[g-1].stage_q;
         end
      end
   end

   assign sync_o = g_stage[STAGES-1].stage_q;

endmodule

// File: rtl/sleep_guard_win_cnt.sv
module sleep_guard_win_cnt
   import sleep_guard_pkg::*;
#(
   parameter int MAX_LOAD = 1,
   localparam int CW = cnt_width(MAX_LOAD)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          zero_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= load_val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q <= CW'(MAX_LOAD))); // R5

endmodule

// File: rtl/sleep_guard_check.sv
module sleep_guard_check (
   input  logic clk,
   input  logic rst_n,
   input  logic forbid_i,
   input  logic open_i,
   input  logic cmd_i,
   input  logic wr_i,
   output logic viol_o,
   output logic wr_ok_o
);

   logic viol_q;

   always_ff @(posedge clk) begin
      if (!rst_n) viol_q <= 1'b0;
      else        viol_q <= viol_q | (forbid_i & (cmd_i | wr_i));
   end

   assign viol_o  = viol_q;
   assign wr_ok_o = wr_i & open_i;

   AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o |=> viol_o); // R7

   AST_VIOL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(viol_o) |-> $past(forbid_i && (cmd_i || wr_i))); // R7

   AST_NO_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      forbid_i |-> !wr_ok_o); // R8

endmodule

// File: rtl/sleep_guard_ctrl.sv
module sleep_guard_ctrl
   import sleep_guard_pkg::*;
#(
   parameter int CLK_PERIOD_PS   = 4000,
   parameter int ENTRY_TIME_PS   = 15000,
   parameter int RECOVER_TIME_PS = 100000,
   parameter int SYNC_STAGES     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req_i,
   input  logic cmd_start_i,
   input  logic wr_req_i,
   output logic icg_en_o,
   output logic desel_o,
   output logic drv_off_o,
   output logic wr_ok_o,
   output logic proto_err_o
);

   localparam int ENTRY_CYC = ceil_div(ENTRY_TIME_PS, CLK_PERIOD_PS);
   localparam int RECOV_CYC = ceil_div(RECOVER_TIME_PS, CLK_PERIOD_PS);
   localparam int CNT_MAX   = (ENTRY_CYC > RECOV_CYC) ? ENTRY_CYC - 1 : RECOV_CYC - 1;
   localparam int CNT_W     = cnt_width(CNT_MAX);
   localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_CYC - 1);
   localparam logic [CNT_W-1:0] RECOV_LOAD = CNT_W'(RECOV_CYC - 1);

   if (CLK_PERIOD_PS <= 0) begin : g_bad_period
      $error("sleep_guard_ctrl: CLK_PERIOD_PS must be positive");
   end
   if (ENTRY_CYC < 1 || RECOV_CYC < 1) begin : g_bad_windows
      $error("sleep_guard_ctrl: entry and recovery windows need at least one cycle");
   end
   if ((SYNC_STAGES + 1) * CLK_PERIOD_PS > ENTRY_TIME_PS) begin : g_slow_off
      $error("sleep_guard_ctrl: synchronizer latency exceeds the driver-off time");
   end

   logic       req_s;
   logic       cnt_load;
   logic [CNT_W-1:0] cnt_val;
   logic       cnt_zero;
   logic       forbid;
   logic       open_wr;
   pwr_state_t state_q, state_d;

   sleep_guard_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (sleep_req_i),
      .sync_o  (req_s)
   );

   sleep_guard_win_cnt #(.MAX_LOAD(CNT_MAX)) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (cnt_load),
      .load_val_i (cnt_val),
      .zero_o     (cnt_zero)
   );

   always_comb begin
      state_d  = state_q;
      cnt_load = 1'b0;
      cnt_val  = '0;
      unique case (state_q)
         PS_AWAKE: begin
            if (req_s) begin
               state_d  = PS_ENTRY;
               cnt_load = 1'b1;
               cnt_val  = ENTRY_LOAD;
            end
         end
         PS_ENTRY: begin
            if (cnt_zero) state_d = PS_ASLEEP;
         end
         PS_ASLEEP: begin
            if (!req_s) begin
               state_d  = PS_RECOVER;
               cnt_load = 1'b1;
               cnt_val  = RECOV_LOAD;
            end
         end
         PS_RECOVER: begin
            if (req_s) begin
               state_d  = PS_ENTRY;
               cnt_load = 1'b1;
               cnt_val  = ENTRY_LOAD;
            end else if (cnt_zero) begin
               state_d  = PS_IDLE;
            end
         end
         PS_IDLE: begin
            if (req_s) begin
               state_d  = PS_ENTRY;
               cnt_load = 1'b1;
               cnt_val  = ENTRY_LOAD;
            end else if (cmd_start_i) begin
               state_d  = PS_AWAKE;
            end
         end
         default: state_d = PS_AWAKE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= PS_AWAKE;
      else        state_q <= state_d;
   end

   assign icg_en_o  = (state_q != PS_ASLEEP);
   assign desel_o   = (state_q == PS_ENTRY) || (state_q == PS_ASLEEP) || (state_q == PS_RECOVER);
   assign drv_off_o = (state_q != PS_AWAKE);
   assign forbid    = (state_q == PS_ENTRY) || (state_q == PS_RECOVER);
   assign open_wr   = (state_q == PS_AWAKE) || (state_q == PS_IDLE);

   sleep_guard_check u_check (
      .clk      (clk),
      .rst_n    (rst_n),
      .forbid_i (forbid),
      .open_i   (open_wr),
      .cmd_i    (cmd_start_i),
      .wr_i     (wr_req_i),
      .viol_o   (proto_err_o),
      .wr_ok_o  (wr_ok_o)
   );

   AST_CLK_STOP_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
      !icg_en_o |-> (desel_o && drv_off_o)); // R4

   AST_SLEEP_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(icg_en_o) |-> $past(state_q == PS_ENTRY)); // R3

   AST_DESEL_DRIVERS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      desel_o |-> drv_off_o); // R3

   AST_WAKE_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drv_off_o) |-> $past(cmd_start_i)); // R6

endmodule

// File: tb/test_sleep_guard_ctrl.sv
`timescale 1ns/1ps
module test_sleep_guard_ctrl;

   localparam int P_PS = 4000;
   localparam int E_PS = 15000;
   localparam int R_PS = 40000;
   localparam int EC   = (E_PS + P_PS - 1) / P_PS;
   localparam int RC   = (R_PS + P_PS - 1) / P_PS;

   localparam int M_AWAKE = 0, M_ENTRY = 1, M_ASLEEP = 2, M_RECOVER = 3, M_IDLE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, cmd = 1'b0, wr = 1'b0;
   logic icg_en, desel, drv_off, wr_ok, perr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sleep_guard_ctrl #(
      .CLK_PERIOD_PS(P_PS), .ENTRY_TIME_PS(E_PS),
      .RECOVER_TIME_PS(R_PS), .SYNC_STAGES(2)
   ) i_sleep_guard_ctrl (
      .clk(clk), .rst_n(rst_n), .sleep_req_i(req), .cmd_start_i(cmd),
      .wr_req_i(wr), .icg_en_o(icg_en), .desel_o(desel), .drv_off_o(drv_off),
      .wr_ok_o(wr_ok), .proto_err_o(perr)
   );

   function automatic logic [2:0] pattern(input int m);
      case (m)
         M_AWAKE:  return 3'b100;
         M_ENTRY:  return 3'b111;
         M_ASLEEP: return 3'b011;
         M_RECOVER:return 3'b111;
         default:  return 3'b101;
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_mode(input string tag, input int m);
      check(tag, int'({icg_en, desel, drv_off}), int'(pattern(m)));
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req = 1'b0; cmd = 1'b0; wr = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(1);
   endtask

   function automatic int entry_mode(input int k);
      if (k <= 2)      return M_AWAKE;
      if (k <= 2 + EC) return M_ENTRY;
      return M_ASLEEP;
   endfunction

   function automatic int rec_mode(input int k);
      if (k <= 2)      return M_ASLEEP;
      if (k <= 2 + RC) return M_RECOVER;
      return M_IDLE;
   endfunction

   initial begin
      step(200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R1: reset state, R8: write gate open while awake
      do_reset();
      check_mode("R1 reset pattern", M_AWAKE);
      check("R1 reset error flag", int'(perr), 0);
      wr = 1'b1; #1;
      check("R8 write passes when awake", int'(wr_ok), 1);
      wr = 1'b0;

      // Entry sweep: command+write pulse in each slot around the entry window (R2 R3 R4 R7 R8)
      for (int k = 0; k <= EC + 4; k++) begin
         do_reset();
         req = 1'b1;
         step(k);
         check_mode($sformatf("R2/R3/R4 entry slot %0d", k), entry_mode(k));
         cmd = 1'b1; wr = 1'b1; #1;
         check($sformatf("R8 write gate entry slot %0d", k), int'(wr_ok),
               (entry_mode(k) == M_AWAKE) ? 1 : 0);
         step(1);
         cmd = 1'b0; wr = 1'b0;
         check($sformatf("R7 flag after entry slot %0d", k), int'(perr),
               (k >= 3 && k <= 2 + EC) ? 1 : 0);
         step(EC + 6 - (k + 1) > 0 ? EC + 6 - (k + 1) : 0);
         check_mode("R4 asleep pattern", M_ASLEEP);
         check($sformatf("R7 flag sticky slot %0d", k), int'(perr),
               (k >= 3 && k <= 2 + EC) ? 1 : 0);
      end

      // Recovery sweep: pulse in each slot after the request drops (R4 R5 R6 R7 R8)
      for (int k = 0; k <= RC + 4; k++) begin
         do_reset();
         req = 1'b1;
         step(EC + 5);
         req = 1'b0;
         step(k);
         check_mode($sformatf("R5/R6 recovery slot %0d", k), rec_mode(k));
         cmd = 1'b1; wr = 1'b1; #1;
         check($sformatf("R8 write gate recovery slot %0d", k), int'(wr_ok),
               (rec_mode(k) == M_IDLE) ? 1 : 0);
         step(1);
         cmd = 1'b0; wr = 1'b0;
         check($sformatf("R7 flag after recovery slot %0d", k), int'(perr),
               (k >= 3 && k <= 2 + RC) ? 1 : 0);
         check_mode($sformatf("R6 state after pulse slot %0d", k),
                    (k >= 3 + RC) ? M_AWAKE : rec_mode(k + 1));
      end

      // R7: write alone inside recovery sets the flag
      do_reset();
      req = 1'b1; step(EC + 5); req = 1'b0; step(5);
      wr = 1'b1; step(1); wr = 1'b0;
      check("R7 write-only in recovery", int'(perr), 1);

      // R7: command alone inside entry sets the flag
      do_reset();
      req = 1'b1; step(4);
      cmd = 1'b1; step(1); cmd = 1'b0;
      check("R7 command-only in entry", int'(perr), 1);

      // R9: re-request from idle, then a drop during entry still completes sleep (R3, R5)
      do_reset();
      req = 1'b1; step(EC + 5); req = 1'b0; step(RC + 4);
      check_mode("R6 idle before re-request", M_IDLE);
      req = 1'b1;
      step(2);
      check_mode("R9 idle during sync", M_IDLE);
      step(1);
      check_mode("R9 entry restarts", M_ENTRY);
      req = 1'b0;
      step(EC);
      check_mode("R3 entry completes after drop", M_ASLEEP);
      step(1);
      check_mode("R5 recovery follows short sleep", M_RECOVER);
      check("R7 no flag without pulses", int'(perr), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule